// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Up-Counter

This block is a single stage of a synchronous up-counter with a parallel preset. A parameter selects its modulus: decade (it counts 0 to 9 and wraps) or full binary (0 to 2^WIDTH-1 and wraps). A second parameter selects how the active-low clear works. It can act at once, independent of the clock, or it can act only at the next rising edge. Every other change of state happens on the rising clock edge.

Two count enables must both be high for the stage to advance. The trickle enable also qualifies the terminal-count output, which is high only when the stage holds its largest value. Several stages form one wide synchronous counter when all stages share the parallel enable and each stage's terminal count drives the trickle enable of the stage above it. Carries then resolve in the same clock, with no ripple clocking. All pins are plain control and status lines, because no data stream passes through this block.

Top module: `sync_stage_counter`

## Requirements
- R1: While `clr_n` is low, `q` becomes 0. With ASYNC_CLR=1 this happens without a clock edge. With ASYNC_CLR=0 it happens at the next rising edge.
- R2: At a rising edge, a low `clr_n` takes priority over load and count. `q` becomes 0 even when `load_n` is low and both enables are high.
- R3: With `clr_n` high and `load_n` low, `q` takes the value of `din` at the rising edge, whatever the levels of `en_par` and `en_trk`.
- R4: With `clr_n` and `load_n` high and both enables high, `q` advances by one at each rising edge. In decade mode 9 wraps to 0. In binary mode 15 wraps to 0.
- R5: With `clr_n` and `load_n` high and either enable low, `q` holds its value.
- R6: `tc` is high exactly when `en_trk` is high and `q` equals the top value (9 in decade mode, 15 in binary mode). `en_par` has no effect on `tc`.
- R7: In decade mode a loaded value from 10 to 15 goes to 0 on the next counting edge, and `tc` stays low while such a value is held.
- R8: With ASYNC_CLR=0, lowering `clr_n` between edges leaves `q` unchanged until the next rising edge.
- R9: With ASYNC_CLR=1, the first rising edge after `clr_n` is released counts from 0 when both enables are high, so `q` becomes 1.
- R10: Three decade stages, chained tc-to-`en_trk` with a shared `en_par`, count 0 to 999 as one decimal counter and wrap to 0. The top stage's `tc` is high at 999, and the whole chain holds while `en_par` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_CLR |
| load_n | input | 1 | Active-low parallel preset enable |
| din | input | WIDTH | Preset value |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also qualifies `tc` |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal count: top value reached while `en_trk` is high |

## Verification
Clear and preset can arrive in the same cycle. The bench provokes this by driving `clr_n` low, `load_n` low and both enables high together. In the asynchronous variant it judges the result right away, before any edge. In the synchronous variant it first confirms the old count is still held and then checks that `q` reads 0 after the edge, not the preset value. Count and terminal count also fall together at the wrap point of each stage. The three-stage chain is swept past 999, and the decimal value of the chain is compared with the bench's own cycle count at every cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;

  function automatic int unsigned top_value(input int unsigned width, input bit decade);
    return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
  endfunction
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import cnt_pkg::*;
(
  input  logic    sync_clr,
  input  logic    load_n,
  input  logic    en_par,
  input  logic    en_trk,
  output ctr_op_e op
);
  always_comb begin
    if (sync_clr)                op = OP_CLEAR;
    else if (!load_n)            op = OP_LOAD;
    else if (en_par && en_trk)   op = OP_COUNT;
    else                         op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_next_value.sv
module ctr_next_value
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b1
) (
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(top_value(WIDTH, DECADE));

  logic [WIDTH-1:0] inc;

  // Values at or above the top (only reachable by preset in decade mode) fold to zero.
  assign inc = (cur >= TOP) ? '0 : cur + 1'b1;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = inc;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_tc_decode.sv
module ctr_tc_decode
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_trk,
  output logic             tc
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(top_value(WIDTH, DECADE));
  assign tc = en_trk && (cur == TOP);
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg #(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] cur
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cur <= '0;
        else        cur <= nxt;
      end
    end else begin : g_sync
      // Clear is already folded into nxt by the operation decode.
      logic unused_clr;
      assign unused_clr = clr_n;
      always_ff @(posedge clk) cur <= nxt;
    end
  endgenerate
endmodule

// File: rtl/sync_stage_counter.sv
module sync_stage_counter
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          DECADE    = 1'b1,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_par,
  input  logic             en_trk,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  ctr_op_e          op;
  logic [WIDTH-1:0] nxt;
  logic             sync_clr;

  assign sync_clr = !ASYNC_CLR && !clr_n;

  ctr_op_decode u_dec (
    .sync_clr (sync_clr),
    .load_n   (load_n),
    .en_par   (en_par),
    .en_trk   (en_trk),
    .op       (op)
  );

  ctr_next_value #(.WIDTH(WIDTH), .DECADE(DECADE)) u_nxt (
    .op  (op),
    .cur (q),
    .din (din),
    .nxt (nxt)
  );

  ctr_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .cur   (q)
  );

  ctr_tc_decode #(.WIDTH(WIDTH), .DECADE(DECADE)) u_tc (
    .cur    (q),
    .en_trk (en_trk),
    .tc     (tc)
  );
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          DECADE    = 1'b1,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] q,
  input logic             tc
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(top_value(WIDTH, DECADE));

  generate
    if (ASYNC_CLR) begin : g_async_chk
      assert_clear_R1: assert property (@(posedge clk) !clr_n |-> q == '0);
    end else begin : g_sync_chk
      assert_clear_R2: assert property (@(posedge clk) !clr_n |=> q == '0);
    end
  endgenerate

  assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  assert_count_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk && q < TOP) |=> q == $past(q) + 1'b1);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_trk)) |=> $stable(q));

  assert_tc_wrap_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (tc && en_par && load_n) |=> q == '0);

  assert_tc_needs_trk_R6: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> en_trk);

  assert_fold_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk && q > TOP) |=> q == '0);
endmodule

bind sync_stage_counter ctr_checker #(
  .WIDTH(WIDTH), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
  .en_par(en_par), .en_trk(en_trk), .q(q), .tc(tc)
);

// File: tb/sync_stage_counter_bench.sv
module sync_stage_counter_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Stage A: decade, asynchronous clear
  logic       a_clr_n = 1'b0, a_load_n = 1'b1, a_ep = 1'b0, a_et = 1'b0;
  logic [3:0] a_din = '0, a_q;
  logic       a_tc;
  sync_stage_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_sync_stage_counter (
    .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .din(a_din),
    .en_par(a_ep), .en_trk(a_et), .q(a_q), .tc(a_tc));

  // Stage B: binary, synchronous clear
  logic       b_clr_n = 1'b0, b_load_n = 1'b1, b_ep = 1'b0, b_et = 1'b0;
  logic [3:0] b_din = '0, b_q;
  logic       b_tc;
  sync_stage_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_bin (
    .clk(clk), .clr_n(b_clr_n), .load_n(b_load_n), .din(b_din),
    .en_par(b_ep), .en_trk(b_et), .q(b_q), .tc(b_tc));

  // Three-stage decade chain
  logic       c_clr_n = 1'b0, c_ep = 1'b0, c_et0 = 1'b0;
  logic [3:0] c_q [3];
  logic [2:0] c_tc;
  for (genvar s = 0; s < 3; s++) begin : g_casc
    logic trk;
    if (s == 0) begin : g_first
      assign trk = c_et0;
    end else begin : g_rest
      assign trk = c_tc[s-1];
    end
    sync_stage_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_casc (
      .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
      .en_par(c_ep), .en_trk(trk), .q(c_q[s]), .tc(c_tc[s]));
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int chain_value();
    return int'(c_q[2]) * 100 + int'(c_q[1]) * 10 + int'(c_q[0]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset A q", int'(a_q), 0);
    check("R1 reset A tc", int'(a_tc), 0);
    check("R1 reset B q", int'(b_q), 0);

    // R9: release the async clear together with enables; first edge counts from 0
    a_clr_n = 1'b1; a_ep = 1'b1; a_et = 1'b1; b_clr_n = 1'b1;
    @(negedge clk);
    check("R9 first edge after release", int'(a_q), 1);

    // Sweep every preset value on the decade stage
    for (int v = 0; v < 16; v++) begin
      a_load_n = 1'b0; a_din = 4'(v); a_ep = 1'b0; a_et = 1'b0;
      @(negedge clk);
      check("R3 load with enables low", int'(a_q), v);
      check("R6 tc low while trickle low", int'(a_tc), 0);
      a_load_n = 1'b1; a_et = 1'b1; a_ep = 1'b0;
      #1;
      check("R6 tc with trickle high, parallel low", int'(a_tc), (v == 9) ? 1 : 0);
      @(negedge clk);
      check("R5 hold when parallel low", int'(a_q), v);
      a_ep = 1'b1; a_et = 1'b0;
      @(negedge clk);
      check("R5 hold when trickle low", int'(a_q), v);
      a_et = 1'b1;
      @(negedge clk);
      if (v > 9) check("R7 out-of-range folds to zero", int'(a_q), 0);
      else       check("R4 decade step", int'(a_q), (v + 1) % 10);
    end

    // Long decade run from 0
    a_load_n = 1'b0; a_din = 4'd0;
    @(negedge clk);
    a_load_n = 1'b1;
    for (int i = 1; i <= 25; i++) begin
      @(negedge clk);
      check("R4 decade run", int'(a_q), i % 10);
    end

    // R2: clear, load and count all requested together (async stage)
    a_clr_n = 1'b0; a_load_n = 1'b0; a_din = 4'd5;
    #1;
    check("R1 async clear without edge", int'(a_q), 0);
    @(negedge clk);
    check("R2 clear beats load", int'(a_q), 0);
    a_clr_n = 1'b1; a_load_n = 1'b1;
    @(negedge clk);
    check("R9 recovery count", int'(a_q), 1);

    // Binary stage: preset to 15, wrap
    b_load_n = 1'b0; b_din = 4'd15;
    @(negedge clk);
    b_load_n = 1'b1; b_ep = 1'b1; b_et = 1'b1;
    #1;
    check("R6 binary tc at 15", int'(b_tc), 1);
    @(negedge clk);
    check("R4 binary wrap", int'(b_q), 0);
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      check("R4 binary run", int'(b_q), i % 16);
    end

    // R8 / R2: synchronous clear with a load requested in the same cycle
    b_clr_n = 1'b0; b_load_n = 1'b0; b_din = 4'd7;
    #1;
    check("R8 sync clear waits for edge", int'(b_q), 4);
    @(negedge clk);
    check("R2 sync clear beats load", int'(b_q), 0);
    b_clr_n = 1'b1; b_load_n = 1'b1;
    @(negedge clk);
    check("R4 after sync clear", int'(b_q), 1);

    // R10: three-stage chain
    c_clr_n = 1'b1; c_ep = 1'b1; c_et0 = 1'b1;
    for (int i = 1; i <= 1005; i++) begin
      @(negedge clk);
      check("R10 chain value", chain_value(), i % 1000);
      if (i % 1000 == 999) check("R10 top tc at 999", int'(c_tc[2]), 1);
      if (i == 500)        check("R10 top tc off at 500", int'(c_tc[2]), 0);
    end
    c_ep = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 chain holds when parallel low", chain_value(), 5);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule